// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block collects 32 interrupt request lines and presents them to a processor as two outputs: a normal interrupt (IRQ) and a fast interrupt (FIQ). Each line has its own configuration word. The word sets a 5-bit priority, chooses between rising-edge capture and level following, and picks the output the line is routed to. A mask register can block any line. Software reads a vector register to learn which line is the current winner. The winner stays frozen from that read until software writes an acknowledge to the control register.

Line numbers are global. A global number splits into a bank number (`number >> 5`) and a bit within the bank (`number & 0x1f`). FIQ routing is kept only in the first bank. A bank built with `FIQ_EN = 0` forces every line to IRQ. Two instances form a two-level cascade: the IRQ output of the second bank drives one request line of the first bank, and the handler then reads the vector register of the second bank.

Top module: `prio_intc_bank`

## Requirements
- R1: After reset, every line is masked (mask reads 0xFFFFFFFF). Status reads 0, both vector registers read 0, and `irq_o` and `fiq_o` are low.
- R2: Each line has a configuration word at word address 0x20 + line. Bit 0 routes the line to FIQ, bit 1 selects level mode (1) or rising-edge mode (0), and bits 6:2 hold the priority. The word reads back as it was written.
- R3: When `FIQ_EN` is 0, the FIQ routing bit is stored and read back as 0, and `fiq_o` never asserts.
- R4: Mask register (address 0x01): a 1 masks a line. A line is eligible when its status bit is 1 and its mask bit is 0. `irq_o` (or `fiq_o`) is high while any eligible line is routed to that output.
- R5: In edge mode, a 0-to-1 change on an input sets its status bit at the next clock edge. The bit stays set after the input falls.
- R6: In level mode, the status bit equals the input value from the previous clock.
- R7: Status register (address 0x00) reads the status bits. Writing it clears every edge-mode status bit whose written data bit is 0, so a write of 0 clears all of them.
- R8: Vector registers (IRQ at 0x02, FIQ at 0x03) return the winner in bits 4:0 and a valid flag in bit 8. They read 0 when no line is eligible. Priority 0 is the highest. When priorities are equal, the lower line index wins.
- R9: A vector read that finds a winner freezes that path's vector. Later reads return the same line until the path is acknowledged, even if a higher-priority line arrives.
- R10: Control register (address 0x04): writing bit 0 acknowledges IRQ and writing bit 1 acknowledges FIQ, so 0x3 acknowledges both. An acknowledge releases the frozen vector and clears the edge-mode status bit of that path's current winner.
- R11: Reads of the control register and of any address not listed above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NLINES | Interrupt request inputs |
| bus_addr | input | 8 | Word address of the register access |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; needed because vector reads freeze the winner |
| bus_rdata | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
A short single pulse on an edge-mode line shows that the capture latches the event rather than follows the input. A level-mode line held high and then dropped shows the opposite behaviour. Three lines pulsed in the same cycle, two of them sharing a priority, separate the priority order from the index tie-break. A higher-priority line arriving while a vector is frozen shows that the freeze holds until the acknowledge. Mixed IRQ and FIQ traffic acknowledged with a single 0x3 write shows that the two paths release and clear independently. A second instance built without FIQ routing checks that the routing bit is forced to 0.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W        = 8;
  localparam int PRIO_W        = 5;
  localparam int CFG_W         = PRIO_W + 2;
  localparam int VEC_VALID_BIT = 8;

  localparam logic [ADDR_W-1:0] ADR_STAT = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_MASK = 8'h01;
  localparam logic [ADDR_W-1:0] ADR_VIRQ = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_VFIQ = 8'h03;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_CFG0 = 8'h20;

  // packed msb first: prio in 6:2, level select in 1, fast route in 0
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              trig_level;
    logic              to_fiq;
  } line_cfg_t;
endpackage

// File: rtl/intc_line_cell.sv
module intc_line_cell
  import intc_pkg::*;
#(
  parameter bit FIQ_EN = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_in,
  input  logic      cfg_we,
  input  line_cfg_t cfg_wdata,
  input  logic      clr_stat,
  output line_cfg_t cfg_q,
  output logic      stat_q
);
  logic      prev_q;
  logic      rise;
  logic      stat_d;
  line_cfg_t cfg_d;

  always_comb begin
    rise  = req_in & ~prev_q;
    cfg_d = cfg_wdata;
    if (!FIQ_EN) cfg_d.to_fiq = 1'b0;
    if (cfg_q.trig_level) stat_d = req_in;
    else                  stat_d = (stat_q & ~clr_stat) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      prev_q <= req_in;
      stat_q <= stat_d;
      if (cfg_we) cfg_q <= cfg_d;
    end
  end

  // R5: a rising input in edge mode is latched
  a_r5_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.trig_level && req_in && !prev_q) |=> stat_q);

  // R6: level mode follows the input one clock later
  a_r6_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.trig_level |=> (stat_q == $past(req_in)));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int IDX_W  = $clog2(NLINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLINES-1:0]        req,
  input  logic [NLINES*PRIO_W-1:0] prio_flat,
  output logic                     valid,
  output logic [IDX_W-1:0]         win
);
  logic [PRIO_W-1:0] best;

  // strict compare scanning upward: lowest index keeps a tie
  always_comb begin
    valid = 1'b0;
    win   = '0;
    best  = '1;
    for (int i = 0; i < NLINES; i++) begin
      if (req[i] && (!valid || (prio_flat[i*PRIO_W +: PRIO_W] < best))) begin
        valid = 1'b1;
        win   = IDX_W'(i);
        best  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // R8: the winner is always a requesting line
  a_r8_win_pending: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> req[win]);
  // R8: no winner only when nothing requests
  a_r8_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (req == '0));
endmodule

// File: rtl/intc_vec_hold.sv
module intc_vec_hold #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live_valid,
  input  logic [IDX_W-1:0] live_idx,
  input  logic             rd_vec,
  input  logic             ack,
  output logic             vec_valid,
  output logic [IDX_W-1:0] vec_idx
);
  logic             lock_q, lock_d;
  logic [IDX_W-1:0] held_q;
  logic             held_en;

  always_comb begin
    held_en = !ack && rd_vec && !lock_q && live_valid;
    lock_d  = lock_q;
    if (ack)          lock_d = 1'b0;
    else if (held_en) lock_d = 1'b1;
    vec_valid = lock_q | live_valid;
    vec_idx   = lock_q ? held_q : live_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      held_q <= '0;
    end else begin
      lock_q <= lock_d;
      if (held_en) held_q <= live_idx;
    end
  end

  // R9: a frozen vector stays put until acknowledged
  a_r9_vector_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !ack) |=> (lock_q && (held_q == $past(held_q))));
  // R10: acknowledge releases the freeze
  a_r10_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !lock_q);
endmodule

// File: rtl/prio_intc_bank.sv
module prio_intc_bank
  import intc_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int DATA_W = 32,
  parameter bit FIQ_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_lines,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int IDX_W = $clog2(NLINES);
  localparam int NPATH = 2;

  logic              wr_stat, wr_mask, wr_ctrl, wr_cfg, cfg_hit;
  logic [ADDR_W-1:0] cfg_off;
  logic [IDX_W-1:0]  cfg_idx;
  logic [NLINES-1:0] mask_q, mask_d;
  logic [NLINES-1:0] stat_vec, route_fiq, clr_vec;
  logic [NLINES*PRIO_W-1:0] prio_flat;
  line_cfg_t         cfg_q [NLINES];

  logic [NLINES-1:0] path_req [NPATH];
  logic              live_v [NPATH];
  logic [IDX_W-1:0]  live_i [NPATH];
  logic              vec_v  [NPATH];
  logic [IDX_W-1:0]  vec_i  [NPATH];
  logic              ack_p  [NPATH];
  logic              rd_p   [NPATH];

  // address decode
  always_comb begin
    cfg_off = bus_addr - ADR_CFG0;
    cfg_hit = (bus_addr >= ADR_CFG0) && (cfg_off < ADDR_W'(NLINES));
    cfg_idx = cfg_off[IDX_W-1:0];
    wr_stat = bus_wr && (bus_addr == ADR_STAT);
    wr_mask = bus_wr && (bus_addr == ADR_MASK);
    wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
    wr_cfg  = bus_wr && cfg_hit;
    ack_p[0] = wr_ctrl && bus_wdata[0];
    ack_p[1] = wr_ctrl && bus_wdata[1];
    rd_p[0]  = bus_rd && (bus_addr == ADR_VIRQ);
    rd_p[1]  = bus_rd && (bus_addr == ADR_VFIQ);
    mask_d   = bus_wdata[NLINES-1:0];
  end

  // per-line state
  for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
    intc_line_cell #(.FIQ_EN(FIQ_EN)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_in    (irq_lines[gi]),
      .cfg_we    (wr_cfg && (cfg_idx == IDX_W'(gi))),
      .cfg_wdata (line_cfg_t'(bus_wdata[CFG_W-1:0])),
      .clr_stat  (clr_vec[gi]),
      .cfg_q     (cfg_q[gi]),
      .stat_q    (stat_vec[gi])
    );
    assign route_fiq[gi] = cfg_q[gi].to_fiq;
    assign prio_flat[gi*PRIO_W +: PRIO_W] = cfg_q[gi].prio;
    assign clr_vec[gi] = (wr_stat && !bus_wdata[gi])
                      || (ack_p[0] && vec_v[0] && (vec_i[0] == IDX_W'(gi)))
                      || (ack_p[1] && vec_v[1] && (vec_i[1] == IDX_W'(gi)));
  end

  assign path_req[0] = stat_vec & ~mask_q & ~route_fiq;
  assign path_req[1] = stat_vec & ~mask_q &  route_fiq;

  // one arbiter and one vector hold per output path
  for (genvar gp = 0; gp < NPATH; gp++) begin : g_path
    intc_arbiter #(.NLINES(NLINES), .IDX_W(IDX_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (path_req[gp]),
      .prio_flat (prio_flat),
      .valid     (live_v[gp]),
      .win       (live_i[gp])
    );
    intc_vec_hold #(.IDX_W(IDX_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .live_valid (live_v[gp]),
      .live_idx   (live_i[gp]),
      .rd_vec     (rd_p[gp]),
      .ack        (ack_p[gp]),
      .vec_valid  (vec_v[gp]),
      .vec_idx    (vec_i[gp])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (wr_mask) mask_q <= mask_d;
  end

  assign irq_o = |path_req[0];
  assign fiq_o = |path_req[1];

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADR_STAT) begin
      bus_rdata[NLINES-1:0] = stat_vec;
    end else if (bus_addr == ADR_MASK) begin
      bus_rdata[NLINES-1:0] = mask_q;
    end else if (bus_addr == ADR_VIRQ) begin
      bus_rdata[IDX_W-1:0]    = vec_i[0];
      bus_rdata[VEC_VALID_BIT] = vec_v[0];
    end else if (bus_addr == ADR_VFIQ) begin
      bus_rdata[IDX_W-1:0]    = vec_i[1];
      bus_rdata[VEC_VALID_BIT] = vec_v[1];
    end else if (cfg_hit) begin
      bus_rdata[CFG_W-1:0] = cfg_q[cfg_idx];
    end
  end

  // R4: a fully masked bank raises nothing
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !(irq_o || fiq_o));

  if (!FIQ_EN) begin : g_nofiq
    // R3: without fast routing the fast output stays low
    a_r3_no_fiq: assert property (@(posedge clk) disable iff (!rst_n)
      !fiq_o);
  end
endmodule

// File: tb/prio_intc_bank_tb.sv
`timescale 1ns/1ps
module prio_intc_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_lines;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata, rdata1;
  logic        irq_o, fiq_o, irq1, fiq1;

  int nchk = 0;
  int nfail = 0;
  bit run = 1'b0;

  always #4 clk = ~clk;

  prio_intc_bank u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  prio_intc_bank #(.FIQ_EN(1'b0)) u_bank1 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(rdata1), .irq_o(irq1), .fiq_o(fiq1));

  // ---------------- behavioural reference model ----------------
  int          m_prio [32];
  bit          m_trig [32];
  bit          m_fiq  [32];
  logic [31:0] m_stat, m_mask, m_prev;
  bit          m_lock [2];
  int          m_held [2];

  function automatic int m_win(int p);
    int best = -1;
    for (int i = 0; i < 32; i++)
      if (m_stat[i] && !m_mask[i] && (int'(m_fiq[i]) == p))
        if (best < 0 || m_prio[i] < m_prio[best]) best = i;
    return best;
  endfunction

  function automatic int m_eff(int p);
    return m_lock[p] ? m_held[p] : m_win(p);
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    int e;
    if (a == 8'h00) return m_stat;
    if (a == 8'h01) return m_mask;
    if (a == 8'h02 || a == 8'h03) begin
      e = m_eff(int'(a) - 2);
      return (e < 0) ? 32'h0 : (32'h100 | e);
    end
    if (a >= 8'h20 && a < 8'h40)
      return (m_prio[a-8'h20] << 2) | (m_trig[a-8'h20] << 1) | m_fiq[a-8'h20];
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = '0; m_mask = '1; m_prev = '0;
      for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_trig[i] = 0; m_fiq[i] = 0; end
      for (int p = 0; p < 2; p++) begin m_lock[p] = 0; m_held[p] = 0; end
    end else begin
      int e[2]; int w[2]; bit ack[2]; logic [31:0] ns; bit clr;
      for (int p = 0; p < 2; p++) begin
        e[p] = m_eff(p); w[p] = m_win(p);
        ack[p] = bus_wr && bus_addr == 8'h04 && bus_wdata[p];
      end
      for (int i = 0; i < 32; i++) begin
        if (m_trig[i]) ns[i] = irq_lines[i];
        else begin
          clr = (bus_wr && bus_addr == 8'h00 && !bus_wdata[i]) ||
                (ack[0] && e[0] == i) || (ack[1] && e[1] == i);
          ns[i] = (m_stat[i] && !clr) || (irq_lines[i] && !m_prev[i]);
        end
      end
      for (int p = 0; p < 2; p++) begin
        if (ack[p]) m_lock[p] = 0;
        else if (bus_rd && int'(bus_addr) == 2 + p && !m_lock[p] && w[p] >= 0) begin
          m_lock[p] = 1; m_held[p] = w[p];
        end
      end
      if (bus_wr && bus_addr == 8'h01) m_mask = bus_wdata;
      if (bus_wr && bus_addr >= 8'h20 && bus_addr < 8'h40) begin
        m_prio[bus_addr-8'h20] = int'(bus_wdata[6:2]);
        m_trig[bus_addr-8'h20] = bus_wdata[1];
        m_fiq[bus_addr-8'h20]  = bus_wdata[0];
      end
      m_stat = ns;
      m_prev = irq_lines;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every clock: outputs against the model (R4), bank without fast route (R3)
  always @(negedge clk) begin
    if (rst_n && run) begin
      chk("R4 irq_o", {31'b0, irq_o}, {31'b0, m_win(0) >= 0});
      chk("R4 fiq_o", {31'b0, fiq_o}, {31'b0, m_win(1) >= 0});
      chk("R3 bank1 fiq_o", {31'b0, fiq1}, 32'h0);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  logic [31:0] last1;
  task automatic rd(string tag, logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    last1 = rdata1;
    chk(tag, d, m_read(a));
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(logic [31:0] bits);
    irq_lines = irq_lines | bits;
    @(negedge clk);
    irq_lines = irq_lines & ~bits;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; irq_lines = '0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; run = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd("R1 mask", 8'h01, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd("R1 stat", 8'h00, d); chk("R1 stat", d, 32'h0);
    rd("R1 virq", 8'h02, d); chk("R1 virq", d, 32'h0);
    rd("R1 vfiq", 8'h03, d); chk("R1 vfiq", d, 32'h0);
    chk("R1 outputs", {30'b0, irq_o, fiq_o}, 32'h0);

    // R2 configuration words
    wr(8'h25, 32'h0C);              // line 5: prio 3, edge, irq
    wr(8'h27, 32'h06);              // line 7: prio 1, level, irq
    wr(8'h2A, 32'h08);              // line 10: prio 2, edge
    wr(8'h2C, 32'h08);              // line 12: prio 2, edge
    wr(8'h23, 32'h11);              // line 3: prio 4, edge, fiq
    rd("R2 cfg7", 8'h27, d); chk("R2 cfg7", d, 32'h06);
    rd("R2 cfg3", 8'h23, d); chk("R2 cfg3", d, 32'h11);
    chk("R3 bank1 cfg3", last1, 32'h10);
    wr(8'h01, 32'h0);

    // R5 edge capture survives the input falling
    pulse(32'h20);
    @(negedge clk); @(negedge clk);
    chk("R5 irq held", {31'b0, irq_o}, 32'h1);
    rd("R5 stat", 8'h00, d); chk("R5 stat", d, 32'h20);
    wr(8'h04, 32'h1);
    rd("R10 stat after ack", 8'h00, d); chk("R10 stat after ack", d, 32'h0);

    // R6 level follow
    irq_lines[7] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 irq high", {31'b0, irq_o}, 32'h1);
    rd("R6 stat", 8'h00, d); chk("R6 stat", d, 32'h80);
    irq_lines[7] = 1'b0;
    @(negedge clk);
    chk("R6 irq low", {31'b0, irq_o}, 32'h0);

    // R8 priority and tie-break
    pulse(32'h0010_1400);
    @(negedge clk);
    rd("R8 virq", 8'h02, d); chk("R8 prio0 wins", d, 32'h114);
    wr(8'h04, 32'h1);
    rd("R8 virq tie", 8'h02, d); chk("R8 tie lower index", d, 32'h10A);

    // R9 freeze against a better late arrival
    pulse(32'h4);
    @(negedge clk);
    rd("R9 virq", 8'h02, d); chk("R9 frozen", d, 32'h10A);
    wr(8'h04, 32'h1);
    rd("R9 virq next", 8'h02, d); chk("R9 after release", d, 32'h102);
    wr(8'h04, 32'h1);

    // R7 status write clears
    rd("R7 stat", 8'h00, d); chk("R7 stat before", d, 32'h1000);
    wr(8'h00, 32'h0);
    rd("R7 stat", 8'h00, d); chk("R7 stat cleared", d, 32'h0);

    // R10 fast path and joint acknowledge
    pulse(32'h8);
    @(negedge clk);
    chk("R10 fiq up", {30'b0, irq_o, fiq_o}, 32'h1);
    rd("R10 vfiq", 8'h03, d); chk("R10 vfiq", d, 32'h103);
    pulse(32'h20);
    @(negedge clk);
    wr(8'h04, 32'h3);
    chk("R10 both low", {30'b0, irq_o, fiq_o}, 32'h0);
    rd("R10 stat", 8'h00, d); chk("R10 stat", d, 32'h0);

    // R4 mask hides but keeps status
    pulse(32'h20);
    @(negedge clk);
    wr(8'h01, 32'h20);
    chk("R4 masked low", {31'b0, irq_o}, 32'h0);
    rd("R4 virq", 8'h02, d); chk("R4 virq none", d, 32'h0);
    rd("R4 stat", 8'h00, d); chk("R4 stat kept", d, 32'h20);
    wr(8'h01, 32'h0);
    chk("R4 unmasked high", {31'b0, irq_o}, 32'h1);
    wr(8'h00, 32'h0);

    // R11 zero reads
    rd("R11 gap", 8'h10, d); chk("R11 gap", d, 32'h0);
    rd("R11 ctrl", 8'h04, d); chk("R11 ctrl", d, 32'h0);
    rd("R11 past cfg", 8'h40, d); chk("R11 past cfg", d, 32'h0);

    @(negedge clk);
    run = 1'b0;
    summary();
  end
endmodule